// File: doc/BRIEF.md
# Byte-Granular Width-Converting Packing FIFO

This block sits between a DMA engine that delivers data one 32-bit word at a time and a parallel output interface, for example a display or audio serializer, that consumes data in units of 1, 2, 3, 4 or 8 bytes. Storage is an array of bytes. Writes deposit whole words, and the read side takes an output unit from any byte position. A 24-bit stream therefore packs densely with no padding byte per word.

A transfer starts with a one-cycle start strobe that loads the number of output units to emit. Units leave through a valid/ready port that is 64 bits wide. When the last unit of the transfer has been taken, a single-cycle completion flag marks the end. Any bytes still buffered at that point are dropped, so a transfer can be shorter than the words that were written for it. The output width can be changed only while the FIFO holds no data. The capacity is always a whole number of 192-byte blocks, so every unit size divides the capacity.

Top module: `bytepack_fifo`

## Requirements
- R1: Each accepted write (wr_valid and wr_ready high at a clock edge) stores all four bytes of wr_data in little-endian order: bits 7:0 go to the lowest byte address of the four, bits 31:24 to the highest.
- R2: unit_sel codes are 0 for 1 byte, 1 for 2 bytes, 2 for 3 bytes, 3 for 4 bytes and 4 for 8 bytes. Codes 5 to 7 are ignored, and the width in force stays as it was.
- R3: An output unit is built from consecutive byte addresses, lowest address in rd_data bits 7:0. Bits above the unit width read as zero.
- R4: Each output handshake advances the read position by exactly the unit size, so units in the 3-byte mode straddle word boundaries without gaps.
- R5: rd_valid is high only when the remaining transfer length is nonzero and at least one full unit of bytes is stored.
- R6: The capacity is 192 times DEPTH_BLOCKS bytes. wr_ready is high exactly when at least 4 bytes are free. Byte positions wrap around the end of storage without losing or repeating data.
- R7: A new unit_sel value takes effect only at a clock edge where the FIFO is empty. While it holds data, changes are ignored.
- R8: xfer_done goes high for exactly one cycle, in the cycle that follows the handshake of the final unit of a transfer.
- R9: At the final handshake of a transfer, every byte stored before that edge is discarded. A word written at that same edge is kept.
- R10: After a synchronous reset, the FIFO is empty, wr_ready is high, rd_valid and xfer_done are low, the remaining length is zero and the width is 1 byte.
- R11: A len_start pulse loads len_count as the number of units to emit. Exactly that many handshakes take place before xfer_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | At least four bytes free |
| wr_data | input | 32 | Word to store, little-endian |
| unit_sel | input | 3 | Output unit size code |
| len_start | input | 1 | Load transfer length |
| len_count | input | LEN_W | Number of output units in the transfer |
| rd_valid | output | 1 | Output unit available |
| rd_ready | input | 1 | Consumer takes the unit |
| rd_data | output | 64 | Output unit, zero above its width |
| xfer_done | output | 1 | One-cycle end-of-transfer flag |

## Verification
The FIFO state changes only at clock edges, and rd_valid, rd_data and wr_ready follow from that state combinationally. A word accepted at one edge can therefore appear as output data immediately after that edge, and xfer_done rises one edge after the final handshake. The bench drives inputs one time unit after the rising edge and samples at the falling edge. At each falling edge it compares the outputs with the state its reference model has reached so far, then applies to the model the handshakes that the next rising edge will complete. The expected completion flag is delayed by exactly one such step.

// File: rtl/bytepack_pkg.sv
package bytepack_pkg;

   typedef enum logic [2:0] {
      UNIT_B1 = 3'd0,
      UNIT_B2 = 3'd1,
      UNIT_B3 = 3'd2,
      UNIT_B4 = 3'd3,
      UNIT_B8 = 3'd4
   } unit_mode_e;

   localparam int unsigned BLOCK_BYTES = 192;
   localparam int unsigned WORD_BYTES  = 4;
   localparam int unsigned LANE_BYTES  = 8;

   function automatic logic [3:0] unit_bytes(input unit_mode_e m);
      case (m)
         UNIT_B1: unit_bytes = 4'd1;
         UNIT_B2: unit_bytes = 4'd2;
         UNIT_B3: unit_bytes = 4'd3;
         UNIT_B4: unit_bytes = 4'd4;
         default: unit_bytes = 4'd8;
      endcase
   endfunction

   function automatic logic code_legal(input logic [2:0] c);
      code_legal = (c <= 3'd4);
   endfunction

endpackage

// File: rtl/bytepack_ptr.sv
module bytepack_ptr #(
   parameter int unsigned CAP   = 192,
   parameter int unsigned IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv_en,
   input  logic [3:0]       adv_step,
   input  logic             load_en,
   input  logic [IDX_W-1:0] load_idx,
   input  logic             load_wrap,
   output logic [IDX_W-1:0] idx,
   output logic             wrap
);
   logic [IDX_W:0] sum;

   always_comb sum = {1'b0, idx} + (IDX_W+1)'(adv_step);

   always_ff @(posedge clk) begin
      if (rst) begin
         idx  <= '0;
         wrap <= 1'b0;
      end else if (load_en) begin
         idx  <= load_idx;
         wrap <= load_wrap;
      end else if (adv_en) begin
         if (sum >= (IDX_W+1)'(CAP)) begin
            idx  <= IDX_W'(sum - (IDX_W+1)'(CAP));
            wrap <= ~wrap;
         end else begin
            idx <= IDX_W'(sum);
         end
      end
   end
endmodule

// File: rtl/bytepack_store.sv
module bytepack_store
   import bytepack_pkg::*;
#(
   parameter int unsigned CAP   = 192,
   parameter int unsigned IDX_W = 8
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [31:0]      wr_word,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [3:0]       rd_bytes,
   output logic [63:0]      rd_word
);
   logic [7:0] mem [CAP];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int b = 0; b < WORD_BYTES; b++)
            mem[wr_idx + IDX_W'(b)] <= wr_word[8*b +: 8];
      end
   end

   for (genvar k = 0; k < LANE_BYTES; k++) begin : g_lane
      logic [IDX_W:0]   raw;
      logic [IDX_W-1:0] addr;
      always_comb begin
         raw  = {1'b0, rd_idx} + (IDX_W+1)'(k);
         addr = (raw >= (IDX_W+1)'(CAP)) ? IDX_W'(raw - (IDX_W+1)'(CAP))
                                          : IDX_W'(raw);
         rd_word[8*k +: 8] = (4'(k) < rd_bytes) ? mem[addr] : 8'h00;
      end
   end
endmodule

// File: rtl/bytepack_len.sv
module bytepack_len #(
   parameter int unsigned LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [LEN_W-1:0] load_val,
   input  logic             take,
   output logic             active,
   output logic             last_take,
   output logic             done
);
   logic [LEN_W-1:0] remain;

   always_comb begin
      active    = (remain != '0);
      last_take = take && (remain == LEN_W'(1));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         remain <= '0;
         done   <= 1'b0;
      end else begin
         done <= last_take;
         if (load)
            remain <= load_val;
         else if (take && active)
            remain <= remain - LEN_W'(1);
      end
   end
endmodule

// File: rtl/bytepack_fifo.sv
module bytepack_fifo
   import bytepack_pkg::*;
#(
   parameter int unsigned DEPTH_BLOCKS = 1,
   parameter int unsigned LEN_W        = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_valid,
   output logic             wr_ready,
   input  logic [31:0]      wr_data,
   input  logic [2:0]       unit_sel,
   input  logic             len_start,
   input  logic [LEN_W-1:0] len_count,
   output logic             rd_valid,
   input  logic             rd_ready,
   output logic [63:0]      rd_data,
   output logic             xfer_done
);
   localparam int unsigned CAP   = BLOCK_BYTES * DEPTH_BLOCKS;
   localparam int unsigned IDX_W = $clog2(CAP);
   localparam int unsigned OCC_W = $clog2(CAP + 1);

   if (DEPTH_BLOCKS < 1) begin : g_bad_depth
      $error("bytepack_fifo: DEPTH_BLOCKS must be at least 1");
   end
   if (LEN_W < 1) begin : g_bad_len
      $error("bytepack_fifo: LEN_W must be at least 1");
   end

   unit_mode_e       mode_q;
   logic [3:0]       unit_b;
   logic [IDX_W-1:0] wr_idx, rd_idx;
   logic             wr_wrap, rd_wrap;
   logic [OCC_W-1:0] occ;
   logic             wr_fire, rd_fire;
   logic             len_active, last_take;

   always_comb begin
      unit_b = unit_bytes(mode_q);
      if (wr_wrap == rd_wrap)
         occ = OCC_W'(wr_idx) - OCC_W'(rd_idx);
      else
         occ = OCC_W'(CAP) - OCC_W'(rd_idx) + OCC_W'(wr_idx);
      wr_ready = (occ <= OCC_W'(CAP - WORD_BYTES));
      rd_valid = len_active && (occ >= OCC_W'(unit_b));
      wr_fire  = wr_valid && wr_ready;
      rd_fire  = rd_valid && rd_ready;
   end

   always_ff @(posedge clk) begin
      if (rst)
         mode_q <= UNIT_B1;
      else if ((occ == '0) && code_legal(unit_sel))
         mode_q <= unit_mode_e'(unit_sel);
   end

   bytepack_ptr #(.CAP(CAP), .IDX_W(IDX_W)) wptr_i (
      .clk(clk), .rst(rst),
      .adv_en(wr_fire), .adv_step(4'(WORD_BYTES)),
      .load_en(1'b0), .load_idx('0), .load_wrap(1'b0),
      .idx(wr_idx), .wrap(wr_wrap)
   );

   bytepack_ptr #(.CAP(CAP), .IDX_W(IDX_W)) rptr_i (
      .clk(clk), .rst(rst),
      .adv_en(rd_fire), .adv_step(unit_b),
      .load_en(last_take), .load_idx(wr_idx), .load_wrap(wr_wrap),
      .idx(rd_idx), .wrap(rd_wrap)
   );

   bytepack_store #(.CAP(CAP), .IDX_W(IDX_W)) store_i (
      .clk(clk), .wr_en(wr_fire), .wr_idx(wr_idx), .wr_word(wr_data),
      .rd_idx(rd_idx), .rd_bytes(unit_b), .rd_word(rd_data)
   );

   bytepack_len #(.LEN_W(LEN_W)) len_i (
      .clk(clk), .rst(rst),
      .load(len_start), .load_val(len_count), .take(rd_fire),
      .active(len_active), .last_take(last_take), .done(xfer_done)
   );
endmodule

// File: rtl/bytepack_fifo_chk.sv
module bytepack_fifo_chk #(
   parameter int unsigned DEPTH_BLOCKS = 1
) (
   input logic        clk,
   input logic        rst,
   input logic        wr_valid,
   input logic        wr_ready,
   input logic        rd_valid,
   input logic        rd_ready,
   input logic [63:0] rd_data,
   input logic        xfer_done,
   input logic [2:0]  mode_q,
   input logic        len_active,
   input logic [$clog2(192*DEPTH_BLOCKS+1)-1:0] occ
);
   localparam int unsigned CAP = 192 * DEPTH_BLOCKS;

   a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
      occ <= ($bits(occ))'(CAP));

   a_r5_valid_needs_len: assert property (@(posedge clk) disable iff (rst)
      rd_valid |-> len_active);

   a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
      xfer_done |=> !xfer_done);

   a_r8_done_after_take: assert property (@(posedge clk) disable iff (rst)
      xfer_done |-> $past(rd_valid && rd_ready));

   a_r7_mode_hold: assert property (@(posedge clk) disable iff (rst)
      (occ != '0) |=> $stable(mode_q));

   a_r9_flush_empty: assert property (@(posedge clk) disable iff (rst)
      xfer_done |-> (occ == '0 || occ == ($bits(occ))'(4)));

   a_r1_write_stores: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && wr_ready) |=> (occ != '0));

   a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
      (rd_valid && mode_q == 3'd0) |-> (rd_data[63:8] == '0));
endmodule

bind bytepack_fifo bytepack_fifo_chk #(.DEPTH_BLOCKS(DEPTH_BLOCKS)) chk_i (
   .clk(clk), .rst(rst),
   .wr_valid(wr_valid), .wr_ready(wr_ready),
   .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
   .xfer_done(xfer_done), .mode_q(mode_q), .len_active(len_active),
   .occ(occ)
);

// File: tb/bytepack_fifo_tb.sv
module bytepack_fifo_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CAP        = 192;
   localparam int LEN_W      = 16;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             wr_valid = 1'b0;
   logic             wr_ready;
   logic [31:0]      wr_data = '0;
   logic [2:0]       unit_sel = 3'd0;
   logic             len_start = 1'b0;
   logic [LEN_W-1:0] len_count = '0;
   logic             rd_valid;
   logic             rd_ready = 1'b0;
   logic [63:0]      rd_data;
   logic             xfer_done;

   int checks = 0;
   int errors = 0;
   int done_cnt = 0;
   int cycles = 0;

   logic [7:0] model[$];
   int         exp_unit = 1;
   int         exp_rem = 0;
   logic       exp_done = 1'b0;
   string      cur_tag = "R3";

   bytepack_fifo #(.DEPTH_BLOCKS(1), .LEN_W(LEN_W)) dut_i (
      .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_data(wr_data), .unit_sel(unit_sel), .len_start(len_start),
      .len_count(len_count), .rd_valid(rd_valid), .rd_ready(rd_ready),
      .rd_data(rd_data), .xfer_done(xfer_done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input logic ok, input string tag,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic int code_to_bytes(input logic [2:0] c);
      case (c)
         3'd0: return 1;
         3'd1: return 2;
         3'd2: return 3;
         3'd3: return 4;
         3'd4: return 8;
         default: return -1;
      endcase
   endfunction

   // Reference model: compare at the falling edge, then apply what the next rising edge does
   always @(negedge clk) begin
      if (!rst) begin
         logic       ev;
         logic [63:0] unit_v;
         int          pre_size;
         ev = (exp_rem != 0) && (model.size() >= exp_unit);
         check(rd_valid === ev, "R5", 64'(rd_valid), 64'(ev));
         check(wr_ready === (model.size() <= CAP-4), "R6",
               64'(wr_ready), 64'(model.size() <= CAP-4));
         check(xfer_done === exp_done, "R8", 64'(xfer_done), 64'(exp_done));
         if (xfer_done) done_cnt++;
         pre_size = model.size();
         exp_done = 1'b0;
         if (ev && rd_ready) begin
            unit_v = '0;
            for (int k = 0; k < exp_unit; k++) unit_v[8*k +: 8] = model[k];
            check(rd_data === unit_v, cur_tag, rd_data, unit_v);
            for (int k = 0; k < exp_unit; k++) void'(model.pop_front());
            exp_rem--;
            if (exp_rem == 0) begin
               exp_done = 1'b1;
               model.delete();   // R9: leftover bytes dropped
            end
         end
         if (len_start) exp_rem = int'(len_count);
         if (wr_valid && (pre_size <= CAP-4))
            for (int b = 0; b < 4; b++) model.push_back(wr_data[8*b +: 8]);
         if (pre_size == 0 && code_to_bytes(unit_sel) > 0)
            exp_unit = code_to_bytes(unit_sel);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d expected below 100000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic send_words(input int n, input logic [31:0] seed);
      for (int i = 0; i < n; i++) begin
         wr_valid = 1'b1;
         wr_data  = seed + 32'(i) * 32'h0103_0507;
         @(negedge clk);
         while (!wr_ready) @(negedge clk);
         step();
      end
      wr_valid = 1'b0;
   endtask

   task automatic start_len(input int n);
      len_start = 1'b1;
      len_count = LEN_W'(n);
      step();
      len_start = 1'b0;
   endtask

   task automatic wait_done();
      int start;
      start = done_cnt;
      rd_ready = 1'b1;
      while (done_cnt == start) @(posedge clk);
      #1;
      rd_ready = 1'b0;
   endtask

   initial begin
      repeat (3) step();
      rst = 1'b0;
      @(negedge clk);
      // R10: reset state
      check(wr_ready === 1'b1, "R10", 64'(wr_ready), 64'd1);
      check(rd_valid === 1'b0, "R10", 64'(rd_valid), 64'd0);
      check(xfer_done === 1'b0, "R10", 64'(xfer_done), 64'd0);
      step();

      // R1 R9 R11: 8-bit, one word written, one unit wanted
      cur_tag = "R1";
      unit_sel = 3'd0;
      send_words(1, 32'h1234_5678);
      start_len(1);
      wait_done();
      start_len(2);
      repeat (3) @(negedge clk);
      check(rd_valid === 1'b0, "R9", 64'(rd_valid), 64'd0);
      step();
      send_words(1, 32'hA1B2_C3D4);
      wait_done();

      // R3 R4: 16-bit and 24-bit units
      cur_tag = "R3";
      unit_sel = 3'd1;
      step();
      send_words(2, 32'h0A0B_0C0D);
      start_len(4);
      wait_done();
      cur_tag = "R4";
      unit_sel = 3'd2;
      step();
      send_words(3, 32'h1122_3344);
      start_len(4);
      wait_done();

      // R7: 32-bit, mode change while data held is ignored; stall with rd_ready low
      cur_tag = "R7";
      unit_sel = 3'd3;
      step();
      send_words(2, 32'hCAFE_0001);
      unit_sel = 3'd0;
      start_len(2);
      repeat (3) step();
      wait_done();

      // R2: illegal code leaves the width unchanged (1 byte now)
      cur_tag = "R2";
      unit_sel = 3'd5;
      step();
      send_words(1, 32'h5566_7788);
      start_len(4);
      wait_done();

      // R6: fill in 64-bit mode, block, drain, then wrap in 24-bit mode
      cur_tag = "R6";
      unit_sel = 3'd4;
      step();
      send_words(48, 32'h0102_0304);
      wr_valid = 1'b1;
      wr_data  = 32'hDEAD_BEEF;
      @(negedge clk);
      check(wr_ready === 1'b0, "R6", 64'(wr_ready), 64'd0);
      step(); step();
      wr_valid = 1'b0;
      start_len(24);
      wait_done();
      unit_sel = 3'd2;
      step();
      send_words(6, 32'h7766_5544);
      start_len(8);
      wait_done();
      send_words(3, 32'h0F1E_2D3C);
      start_len(3);
      wait_done();

      repeat (3) step();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule